// File: doc/BRIEF.md
# DDR Mode Register Programming Unit

This block is the controller-side image of a DDR memory's mode register. Each cycle it sees one command slot: a valid strobe, a flag that marks the command as a mode-register-set, the two bank-address bits and the thirteen row-address bits. A mode-register-set that targets bank-address `00` is a write to this register. The block splits the address into fields and keeps only the legal ones. It then presents the burst length as a beat count, the burst ordering as one bit and the read latency in half-cycle units.

Writes are accepted only while the memory reports that every bank is idle. Each accepted write starts a settle window. While the window runs, `busy` stays high and any command that arrives is refused and flagged. When a write requests a DLL reset, the block emits a one-cycle pulse. The stored copy of that request bit then reads back as zero.

Top module: `ddr_modereg_unit`

## Requirements
- R1: A mode-register-set with a bank-address value other than `00` changes no output. It raises neither the error flag, the violation flag nor `busy`.
- R2: Address bits [2:0] set the burst length. Code `001` gives 2, `010` gives 4 and `011` gives 8, shown on `burst_len` as the beat count. Any other code leaves `burst_len` unchanged.
- R3: Address bit 3 sets `burst_interleaved`: 0 selects sequential order and 1 selects interleaved order. It is stored on every accepted write.
- R4: Address bits [6:4] set the read latency, shown on `cas_half` in half cycles. Code `101` gives 3, `010` gives 4, `110` gives 5 and `011` gives 6. Any other code leaves `cas_half` unchanged.
- R5: `code_error` is high for exactly the one cycle after an accepted write in which the burst-length, latency or operating-mode field holds a reserved code. It is low at every other time.
- R6: Address bits [12:7] are the operating mode. Only all-zero and "bit 8 alone" are legal. A legal write stores the field with bit 8 cleared, so `op_mode[1]` always reads 0. Any other value leaves `op_mode` unchanged.
- R7: An accepted write whose operating mode is exactly bit 8 makes `dll_reset` high for exactly the one following cycle.
- R8: A mode-register-set to bank-address `00` while `banks_idle` is 0 and `busy` is 0 is ignored. `violation` is high for the one following cycle.
- R9: After an accepted write, `busy` is high for `SETTLE_CYC` cycles (default 2). Any command that arrives while `busy` is high is ignored and makes `violation` high in the following cycle.
- R10: A synchronous reset sets burst length 2, sequential order, `cas_half` = 4 and `op_mode` = 0. It clears `busy`, `dll_reset`, `code_error` and `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command occupies this cycle |
| cmd_is_mrs | input | 1 | The command is a mode-register-set |
| cmd_ba | input | 2 | Bank-address bits of the command |
| cmd_addr | input | 13 | Row-address bits of the command |
| banks_idle | input | 1 | All banks are idle |
| burst_len | output | 4 | Burst length in beats (2, 4 or 8) |
| burst_interleaved | output | 1 | 1 for interleaved order, 0 for sequential |
| cas_half | output | 3 | Read latency in half cycles |
| op_mode | output | 6 | Stored operating-mode field, bit 1 always 0 |
| dll_reset | output | 1 | One-cycle DLL reset request |
| code_error | output | 1 | Reserved code seen in the last accepted write |
| busy | output | 1 | Settle window running |
| violation | output | 1 | Last command was refused |

## Verification
The assertions assume that the inputs are driven to known values and change only between clock edges. They also assume that `SETTLE_CYC` is at least 1, so that two accepted writes can never fall in adjacent cycles. The one-cycle checks on `dll_reset` and `code_error` rely on that spacing. The bench drives every input at the falling edge. It lets each accepted write's window run out before it issues the next write, except where it provokes a refusal on purpose to exercise R8 and R9.

// File: rtl/ddr_mr_pkg.sv
package ddr_mr_pkg;

    localparam int unsigned ADDR_W = 13;
    localparam int unsigned BA_W   = 2;
    localparam int unsigned OP_W   = 6;

    localparam logic [2:0]      RST_BL_CODE = 3'b001;
    localparam logic [2:0]      RST_CL_CODE = 3'b010;
    localparam logic [OP_W-1:0] OP_NORMAL   = '0;
    localparam logic [OP_W-1:0] OP_DLL_ONLY = 6'b000010;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic [2:0]      cl_code;
        logic            interleave;
        logic [2:0]      bl_code;
    } mr_word_t;

    typedef struct packed {
        logic bl_ok;
        logic cl_ok;
        logic op_ok;
        logic dll_req;
    } mr_check_t;

    function automatic logic bl_is_legal(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
    endfunction

    function automatic logic cl_is_legal(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b011) || (c == 3'b101) || (c == 3'b110);
    endfunction

    function automatic logic [3:0] bl_beats(input logic [2:0] c);
        logic [3:0] r;
        case (c)
            3'b010:  r = 4'd4;
            3'b011:  r = 4'd8;
            default: r = 4'd2;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] cl_halves(input logic [2:0] c);
        logic [2:0] r;
        case (c)
            3'b101:  r = 3'd3;
            3'b110:  r = 3'd5;
            3'b011:  r = 3'd6;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mr_field_check.sv
module mr_field_check
    import ddr_mr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output mr_word_t          word,
    output mr_check_t         chk
);
    always_comb begin
        word        = mr_word_t'(addr);
        chk.bl_ok   = bl_is_legal(word.bl_code);
        chk.cl_ok   = cl_is_legal(word.cl_code);
        chk.op_ok   = (word.op == OP_NORMAL) || (word.op == OP_DLL_ONLY);
        chk.dll_req = (word.op == OP_DLL_ONLY);
    end
endmodule

// File: rtl/mr_settle_timer.sv
module mr_settle_timer #(
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (start)          cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R9: the window never runs past its programmed length
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD);
endmodule

// File: rtl/mr_store.sv
module mr_store
    import ddr_mr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  mr_word_t        word,
    input  mr_check_t       chk,
    output logic [2:0]      bl_code_q,
    output logic            interleave_q,
    output logic [2:0]      cl_code_q,
    output logic [OP_W-1:0] op_q,
    output logic            dll_pulse_q,
    output logic            err_q
);
    logic any_bad;
    assign any_bad = !(chk.bl_ok && chk.cl_ok && chk.op_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            bl_code_q    <= RST_BL_CODE;
            interleave_q <= 1'b0;
            cl_code_q    <= RST_CL_CODE;
            op_q         <= OP_NORMAL;
            dll_pulse_q  <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            dll_pulse_q <= wr_en && chk.dll_req;
            err_q       <= wr_en && any_bad;
            if (wr_en) begin
                interleave_q <= word.interleave;
                if (chk.bl_ok) bl_code_q <= word.bl_code;
                if (chk.cl_ok) cl_code_q <= word.cl_code;
                if (chk.op_ok) op_q      <= word.op & ~OP_DLL_ONLY;
            end
        end
    end

    // R6: the self-clearing bit never reads back as set
    assert_dll_bit_clear_R6: assert property (@(posedge clk) disable iff (rst)
        op_q[1] == 1'b0);
    // R2: stored burst code is always one of the legal values
    assert_bl_legal_R2: assert property (@(posedge clk) disable iff (rst)
        bl_is_legal(bl_code_q));
    // R4: stored latency code is always one of the legal values
    assert_cl_legal_R4: assert property (@(posedge clk) disable iff (rst)
        cl_is_legal(cl_code_q));
    // R4: a reserved latency code keeps the previous setting
    assert_cl_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !chk.cl_ok) |=> $stable(cl_code_q));
endmodule

// File: rtl/ddr_modereg_unit.sv
module ddr_modereg_unit
    import ddr_mr_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic        cmd_is_mrs,
    input  logic [1:0]  cmd_ba,
    input  logic [12:0] cmd_addr,
    input  logic        banks_idle,
    output logic [3:0]  burst_len,
    output logic        burst_interleaved,
    output logic [2:0]  cas_half,
    output logic [5:0]  op_mode,
    output logic        dll_reset,
    output logic        code_error,
    output logic        busy,
    output logic        violation
);
    mr_word_t  word;
    mr_check_t chk;
    logic      sel_mr, wr_en, refuse, viol_q;
    logic [2:0] bl_code_q, cl_code_q;

    mr_field_check u_check (
        .addr (cmd_addr),
        .word (word),
        .chk  (chk)
    );

    assign sel_mr = cmd_valid && !busy && cmd_is_mrs && (cmd_ba == 2'b00);
    assign wr_en  = sel_mr && banks_idle;
    assign refuse = (cmd_valid && busy) || (sel_mr && !banks_idle);

    mr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (wr_en),
        .busy  (busy)
    );

    mr_store u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .word         (word),
        .chk          (chk),
        .bl_code_q    (bl_code_q),
        .interleave_q (burst_interleaved),
        .cl_code_q    (cl_code_q),
        .op_q         (op_mode),
        .dll_pulse_q  (dll_reset),
        .err_q        (code_error)
    );

    always_ff @(posedge clk) begin
        if (rst) viol_q <= 1'b0;
        else     viol_q <= refuse;
    end

    assign violation = viol_q;
    assign burst_len = bl_beats(bl_code_q);
    assign cas_half  = cl_halves(cl_code_q);

    // R9: an accepted write opens the settle window
    assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> busy);
    // R9: a command during the window is flagged
    assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> violation);
    // R8: a write with banks not idle changes nothing and is flagged
    assert_not_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_mr && !banks_idle) |=> (violation && $stable(burst_len) && $stable(cas_half)));
    // R7: the DLL reset request lasts one cycle
    assert_dll_single_R7: assert property (@(posedge clk) disable iff (rst)
        dll_reset |=> !dll_reset);
    // R5: the error flag lasts one cycle
    assert_err_single_R5: assert property (@(posedge clk) disable iff (rst)
        code_error |=> !code_error);
    // R1: other bank-address values leave the settings alone
    assert_other_ba_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_is_mrs && !busy && cmd_ba != 2'b00)
            |=> ($stable(burst_len) && $stable(cas_half) && !code_error));
    // R4: latency always lies in the legal half-cycle range
    assert_cas_range_R4: assert property (@(posedge clk) disable iff (rst)
        (cas_half >= 3'd3) && (cas_half <= 3'd6));
endmodule

// File: tb/ddr_modereg_unit_tb_top.sv
module ddr_modereg_unit_tb_top;
    localparam int WAITC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_is_mrs = 1'b0, banks_idle = 1'b1;
    logic [1:0]  cmd_ba = 2'b00;
    logic [12:0] cmd_addr = '0;
    logic [3:0]  burst_len;
    logic        burst_interleaved;
    logic [2:0]  cas_half;
    logic [5:0]  op_mode;
    logic        dll_reset, code_error, busy, violation;

    always #2 clk = ~clk;

    ddr_modereg_unit #(.SETTLE_CYC(WAITC)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_is_mrs(cmd_is_mrs),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .banks_idle(banks_idle),
        .burst_len(burst_len), .burst_interleaved(burst_interleaved),
        .cas_half(cas_half), .op_mode(op_mode), .dll_reset(dll_reset),
        .code_error(code_error), .busy(busy), .violation(violation)
    );

    typedef struct {
        logic [22:0] v;   // {bl4, bt, cas3, op6, dll, err, busy, viol, pad5}
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    logic [3:0] m_bl = 4'd2;
    logic       m_bt = 1'b0;
    logic [2:0] m_cas = 3'd4;
    logic [5:0] m_op = 6'd0;
    int         m_cnt = 0;

    function automatic logic [22:0] pack(logic [3:0] bl, logic bt, logic [2:0] cs,
                                         logic [5:0] op, logic d, logic e, logic b, logic vi);
        return {bl, bt, cs, op, d, e, b, vi, 5'd0};
    endfunction

    function automatic logic [12:0] mk(logic [5:0] op, logic [2:0] cl, logic bt, logic [2:0] bl);
        return {op, cl, bt, bl};
    endfunction

    task automatic step(input logic v, input logic m, input logic [1:0] ba,
                        input logic [12:0] a, input logic idle, input string tag);
        logic d, e, vi, acc;
        item_t it;
        @(negedge clk);
        cmd_valid = v; cmd_is_mrs = m; cmd_ba = ba; cmd_addr = a; banks_idle = idle;
        d = 0; e = 0; vi = 0; acc = 0;
        if (v && m_cnt != 0) vi = 1;
        else if (v && m && ba == 2'b00) begin
            if (!idle) vi = 1;
            else acc = 1;
        end
        if (acc) begin
            m_bt = a[3];
            case (a[2:0])
                3'b001: m_bl = 4'd2;
                3'b010: m_bl = 4'd4;
                3'b011: m_bl = 4'd8;
                default: e = 1;
            endcase
            case (a[6:4])
                3'b101: m_cas = 3'd3;
                3'b010: m_cas = 3'd4;
                3'b110: m_cas = 3'd5;
                3'b011: m_cas = 3'd6;
                default: e = 1;
            endcase
            if (a[12:7] == 6'd0) m_op = 6'd0;
            else if (a[12:7] == 6'b000010) begin m_op = 6'd0; d = 1; end
            else e = 1;
            m_cnt = WAITC;
        end else if (m_cnt > 0) m_cnt = m_cnt - 1;
        it.v = pack(m_bl, m_bt, m_cas, m_op, d, e, (m_cnt != 0), vi);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_n(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 2'b00, '0, 1, tag);
    endtask

    // monitor: compares one item per cycle, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [22:0] act;
                it = q.pop_front();
                act = pack(burst_len, burst_interleaved, cas_half, op_mode,
                           dll_reset, code_error, busy, violation);
                total++;
                if (act !== it.v) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.v);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        total++;
        if (pack(burst_len, burst_interleaved, cas_half, op_mode, dll_reset, code_error, busy, violation)
            !== pack(4'd2, 0, 3'd4, 6'd0, 0, 0, 0, 0)) begin
            bad++;
            $display("FAIL R10 reset actual=%h expected=%h",
                pack(burst_len, burst_interleaved, cas_half, op_mode, dll_reset, code_error, busy, violation),
                pack(4'd2, 0, 3'd4, 6'd0, 0, 0, 0, 0));
        end
        // R2 R4 R9: BL4, CL2, then busy window
        step(1, 1, 2'b00, mk(6'd0, 3'b010, 0, 3'b010), 1, "R2_R9 bl4");
        idle_n(3, "R9 settle");
        // R2 R3 R4: BL8 interleaved CL3
        step(1, 1, 2'b00, mk(6'd0, 3'b011, 1, 3'b011), 1, "R3_R4 bl8 il cl3");
        // R9: mode-register-set during busy is refused
        step(1, 1, 2'b00, mk(6'd0, 3'b101, 0, 3'b001), 1, "R9 refuse mrs");
        // R9: other command during busy is refused
        step(1, 0, 2'b01, '0, 1, "R9 refuse other");
        idle_n(2, "R9 drain");
        step(1, 1, 2'b00, mk(6'd0, 3'b101, 0, 3'b001), 1, "R4 cl1.5");
        idle_n(2, "R4 gap");
        step(1, 1, 2'b00, mk(6'd0, 3'b110, 1, 3'b010), 1, "R4 cl2.5");
        idle_n(2, "R4 gap2");
        // R2 R5: reserved burst codes
        step(1, 1, 2'b00, mk(6'd0, 3'b011, 0, 3'b000), 1, "R5 bl000");
        idle_n(2, "R5 gap");
        step(1, 1, 2'b00, mk(6'd0, 3'b010, 1, 3'b111), 1, "R2 bl111");
        idle_n(2, "R5 gap2");
        // R4 R5: reserved latency codes
        step(1, 1, 2'b00, mk(6'd0, 3'b000, 0, 3'b011), 1, "R4_R5 cl000");
        idle_n(2, "R4 gap3");
        step(1, 1, 2'b00, mk(6'd0, 3'b111, 0, 3'b001), 1, "R4 cl111");
        idle_n(2, "R4 gap4");
        // R1: other bank addresses
        step(1, 1, 2'b01, mk(6'd0, 3'b101, 1, 3'b010), 1, "R1 ba01");
        step(1, 1, 2'b10, mk(6'd0, 3'b110, 1, 3'b011), 1, "R1 ba10");
        step(1, 1, 2'b11, mk(6'd0, 3'b000, 1, 3'b000), 1, "R1 ba11");
        idle_n(1, "R1 after");
        // R8: banks not idle
        step(1, 1, 2'b00, mk(6'd0, 3'b101, 1, 3'b011), 0, "R8 not idle");
        idle_n(2, "R8 after");
        // R7 R6: DLL reset request
        step(1, 1, 2'b00, mk(6'b000010, 3'b010, 0, 3'b010), 1, "R7 dll");
        idle_n(3, "R7_R6 after");
        // R6 R5: reserved operating mode
        step(1, 1, 2'b00, mk(6'b000100, 3'b011, 1, 3'b011), 1, "R6 op reserved");
        idle_n(2, "R6 gap");
        step(1, 1, 2'b00, mk(6'b000011, 3'b101, 0, 3'b001), 1, "R6 op mixed");
        idle_n(3, "final");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule